// File: doc/BRIEF.md
# Prefetch-for-write request handler

This block receives decoded hints that a byte of memory is about to be written. It checks the instruction encoding and screens each request. Then it does one of four things. It faults the request, drops it, completes it with no data movement, or sends a fetch-with-ownership for the cache line that holds the byte. That fetch also invalidates every other cached copy of the line. The caller gives the byte address, the memory type of the address, and the lowest-level cache tag state for that line. The lookup is combinational: the block shows the line address on a lookup port, and the tag state comes back in the same cycle.

Accepted prefetches are held in a small tracking table until the bus reports that they are complete. A request for a line that is already outstanding is merged into the existing entry. A request that finds the table full is dropped, so the request port never stalls. Fences and other memory operations have no effect on the table. Only the serialize-drain handshake waits for it to empty.

Top module: `pfw_handler`

## Requirements
- R1: A request is recognised only when the first opcode byte is 8'h0F, the second is 8'h0D and the ModRM reg field (bits 5:3) equals 1. Any other request produces no outcome, no fault, no debug change and no bus request.
- R2: A recognised request with the lock flag set produces outcome code 0 (fault) and a one-cycle `udFault` pulse. It allocates nothing, whatever its other fields are. The checks run in a fixed priority order: lock, register operand, memory type, owned hit, merge, table full.
- R3: A recognised, unlocked request whose ModRM mod field (bits 7:6) is 2'b11 produces outcome code 1. It sets the sticky `dbgRegOperand` bit, raises no fault and sends no bus request.
- R4: A remaining request whose memory type is not writeback (writeback is code 3'd6) produces outcome code 2. It causes no bus activity.
- R5: A remaining request whose lookup state is exclusive (2) or modified (3) produces outcome code 3. It sends no bus request. Lookup states 0 and 1 mean invalid and shared.
- R6: `lkLineAddr` and `busReqAddr` are the request address with its low log2(LINE_BYTES) bits cleared. LINE_BYTES is at least 32.
- R7: A remaining request that reaches the end of the priority chain produces outcome code 6 and allocates a table entry. Its bus request is a read-for-ownership (`busReqUpgrade`=0) when the line is invalid. It is an upgrade/invalidate with no data (`busReqUpgrade`=1) when the line is shared.
- R8: A remaining request whose line matches an outstanding entry produces outcome code 4. It adds no entry and sends no new bus request.
- R9: When all ENTRIES entries are occupied and there is no match, the request produces outcome code 5 and is dropped. The request port never stalls.
- R10: An entry stays outstanding after its bus handshake until a `busDoneValid` pulse carries its `busReqId`. New requests are accepted throughout.
- R11: `serAck` is high exactly when `serReq` is high and no entry is outstanding.
- R12: `outValid`, `outKind` and `udFault` appear one cycle after the request cycle. A newly allocated entry raises `busReqValid` from that same cycle. `busReqValid` stays high while any entry is still unsent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqOpEsc | input | 8 | First opcode byte |
| reqOpMain | input | 8 | Second opcode byte |
| reqModrm | input | 8 | ModRM byte |
| reqLock | input | 1 | Lock prefix present |
| reqAddr | input | ADDR_W | Byte address |
| reqMemType | input | 3 | Memory type of the address |
| lkLineAddr | output | ADDR_W | Line address sent to tag lookup |
| lkState | input | 2 | Local tag state of that line |
| busReqValid | output | 1 | Bus request pending |
| busReqUpgrade | output | 1 | 1 = upgrade/invalidate, 0 = read-for-ownership |
| busReqAddr | output | ADDR_W | Line address of the bus request |
| busReqId | output | ID_W | Table slot of the bus request |
| busReqReady | input | 1 | Bus accepts the request |
| busDoneValid | input | 1 | Bus completion pulse |
| busDoneId | input | ID_W | Slot that completed |
| serReq | input | 1 | Serializing instruction waits for drain |
| serAck | output | 1 | Drain complete |
| outValid | output | 1 | Outcome present |
| outKind | output | 3 | Outcome code |
| udFault | output | 1 | Invalid-opcode fault pulse |
| dbgRegOperand | output | 1 | Sticky register-operand debug bit |

## Verification
Outcome and fault are due exactly one cycle after the request cycle. The bench drives inputs on the falling edge and compares these outputs on the next falling edge against the expectation it recorded when it drove the request. The bus request is read combinationally from table registers. It is checked on every falling edge against a bench model of outstanding lines, which is updated at the moment the matching input is driven. `lkLineAddr` and `serAck` are combinational. They are sampled one nanosecond after the inputs change and before the next edge, respectively.

// File: rtl/pfw_pkg.sv
package pfw_pkg;

  typedef enum logic [2:0] {
    OUT_FAULT     = 3'd0,
    OUT_REGNOP    = 3'd1,
    OUT_DROP_TYPE = 3'd2,
    OUT_OWNED     = 3'd3,
    OUT_MERGED    = 3'd4,
    OUT_DROP_FULL = 3'd5,
    OUT_ISSUED    = 3'd6
  } outKind_e;

  localparam logic [2:0] MEMTYPE_WB = 3'd6;
  localparam logic [7:0] OPC_ESC    = 8'h0F;
  localparam logic [7:0] OPC_MAIN   = 8'h0D;
  localparam logic [2:0] REG_SEL    = 3'd1;

  typedef struct packed {
    logic alloc;
    logic upgrade;
  } pfwStrobe_t;

endpackage

// File: rtl/pfw_ctrl.sv
module pfw_ctrl
  import pfw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [7:0] reqOpEsc,
  input  logic [7:0] reqOpMain,
  input  logic [7:0] reqModrm,
  input  logic       reqLock,
  input  logic [2:0] reqMemType,
  input  logic [1:0] lkState,
  input  logic       matchHit,
  input  logic       tableFull,
  output pfwStrobe_t strobe,
  output logic       outValid,
  output outKind_e   outKind,
  output logic       udFault,
  output logic       dbgRegOperand
);

  logic     recog;
  logic     regOperand;
  outKind_e kindNext;
  logic     unusedRm;

  assign unusedRm   = ^reqModrm[2:0];
  assign recog      = reqValid && (reqOpEsc == OPC_ESC) && (reqOpMain == OPC_MAIN)
                      && (reqModrm[5:3] == REG_SEL);
  assign regOperand = (reqModrm[7:6] == 2'b11);

  // priority chain: lock, register operand, memory type, owned hit, merge, full
  always_comb begin
    strobe   = '0;
    kindNext = OUT_FAULT;
    if (reqLock) begin
      kindNext = OUT_FAULT;
    end else if (regOperand) begin
      kindNext = OUT_REGNOP;
    end else if (reqMemType != MEMTYPE_WB) begin
      kindNext = OUT_DROP_TYPE;
    end else if (lkState[1]) begin
      kindNext = OUT_OWNED;
    end else if (matchHit) begin
      kindNext = OUT_MERGED;
    end else if (tableFull) begin
      kindNext = OUT_DROP_FULL;
    end else begin
      kindNext       = OUT_ISSUED;
      strobe.alloc   = recog;
      strobe.upgrade = (lkState == 2'd1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid      <= 1'b0;
      outKind       <= OUT_FAULT;
      udFault       <= 1'b0;
      dbgRegOperand <= 1'b0;
    end else begin
      outValid <= recog;
      outKind  <= recog ? kindNext : OUT_FAULT;
      udFault  <= recog && reqLock;
      if (recog && !reqLock && regOperand) dbgRegOperand <= 1'b1;
    end
  end

  p_lock_fault_r2: assert property (@(posedge clk) disable iff (!rstN)
    (recog && reqLock) |=> (udFault && outValid && outKind == OUT_FAULT));

  p_reg_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    dbgRegOperand |=> dbgRegOperand);

  p_type_drop_r4: assert property (@(posedge clk) disable iff (!rstN)
    (recog && !reqLock && !regOperand && reqMemType != MEMTYPE_WB)
      |=> (outKind == OUT_DROP_TYPE && !udFault));

  p_owned_hit_r5: assert property (@(posedge clk) disable iff (!rstN)
    (recog && !reqLock && !regOperand && reqMemType == MEMTYPE_WB && lkState[1])
      |=> (outKind == OUT_OWNED));

  p_no_overfill_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.alloc |-> !tableFull);

endmodule

// File: rtl/pfw_datapath.sv
module pfw_datapath
  import pfw_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int ENTRIES    = 4,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int ID_W      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] reqAddr,
  input  pfwStrobe_t        strobe,
  output logic [ADDR_W-1:0] lineAddr,
  output logic              matchHit,
  output logic              tableFull,
  output logic              tableEmpty,
  output logic              busReqValid,
  output logic              busReqUpgrade,
  output logic [ADDR_W-1:0] busReqAddr,
  output logic [ID_W-1:0]   busReqId,
  input  logic              busReqReady,
  input  logic              busDoneValid,
  input  logic [ID_W-1:0]   busDoneId
);

  logic [ENTRIES-1:0] entValid, entSent, entUpg, matchVec, pendVec;
  logic [ADDR_W-1:0]  entAddr [ENTRIES];
  logic [ID_W-1:0]    freeIdx, pendIdx;
  logic               unusedLow;

  assign unusedLow = ^reqAddr[OFF_W-1:0];
  assign lineAddr  = {reqAddr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign matchVec[g] = entValid[g] && (entAddr[g] == lineAddr);
    assign pendVec[g]  = entValid[g] && !entSent[g];
  end

  assign matchHit   = |matchVec;
  assign tableFull  = &entValid;
  assign tableEmpty = ~|entValid;

  always_comb begin
    freeIdx = '0;
    pendIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!entValid[i]) freeIdx = ID_W'(i);
      if (pendVec[i])   pendIdx = ID_W'(i);
    end
  end

  assign busReqValid   = |pendVec;
  assign busReqAddr    = entAddr[pendIdx];
  assign busReqUpgrade = entUpg[pendIdx];
  assign busReqId      = pendIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entValid <= '0;
      entSent  <= '0;
      entUpg   <= '0;
      for (int i = 0; i < ENTRIES; i++) entAddr[i] <= '0;
    end else begin
      if (strobe.alloc) begin
        entValid[freeIdx] <= 1'b1;
        entSent[freeIdx]  <= 1'b0;
        entUpg[freeIdx]   <= strobe.upgrade;
        entAddr[freeIdx]  <= lineAddr;
      end
      if (busReqValid && busReqReady) entSent[pendIdx] <= 1'b1;
      if (busDoneValid && entValid[busDoneId] && entSent[busDoneId])
        entValid[busDoneId] <= 1'b0;
    end
  end

  p_line_align_r6: assert property (@(posedge clk) disable iff (!rstN)
    busReqValid |-> (busReqAddr[OFF_W-1:0] == '0));

  p_bus_needs_entry_r10: assert property (@(posedge clk) disable iff (!rstN)
    busReqValid |-> !tableEmpty);

  p_alloc_raises_bus_r12: assert property (@(posedge clk) disable iff (!rstN)
    strobe.alloc |=> busReqValid);

endmodule

// File: rtl/pfw_handler.sv
module pfw_handler
  import pfw_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int ENTRIES    = 4,
  localparam int ID_W      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [7:0]        reqOpEsc,
  input  logic [7:0]        reqOpMain,
  input  logic [7:0]        reqModrm,
  input  logic              reqLock,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [2:0]        reqMemType,
  output logic [ADDR_W-1:0] lkLineAddr,
  input  logic [1:0]        lkState,
  output logic              busReqValid,
  output logic              busReqUpgrade,
  output logic [ADDR_W-1:0] busReqAddr,
  output logic [ID_W-1:0]   busReqId,
  input  logic              busReqReady,
  input  logic              busDoneValid,
  input  logic [ID_W-1:0]   busDoneId,
  input  logic              serReq,
  output logic              serAck,
  output logic              outValid,
  output logic [2:0]        outKind,
  output logic              udFault,
  output logic              dbgRegOperand
);

  pfwStrobe_t strobe;
  logic       matchHit, tableFull, tableEmpty;
  outKind_e   kindW;

  pfw_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOpEsc(reqOpEsc),
    .reqOpMain(reqOpMain), .reqModrm(reqModrm), .reqLock(reqLock),
    .reqMemType(reqMemType), .lkState(lkState), .matchHit(matchHit),
    .tableFull(tableFull), .strobe(strobe), .outValid(outValid),
    .outKind(kindW), .udFault(udFault), .dbgRegOperand(dbgRegOperand)
  );

  pfw_datapath #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .ENTRIES(ENTRIES)) u_dp (
    .clk(clk), .rstN(rstN), .reqAddr(reqAddr), .strobe(strobe),
    .lineAddr(lkLineAddr), .matchHit(matchHit), .tableFull(tableFull),
    .tableEmpty(tableEmpty), .busReqValid(busReqValid),
    .busReqUpgrade(busReqUpgrade), .busReqAddr(busReqAddr), .busReqId(busReqId),
    .busReqReady(busReqReady), .busDoneValid(busDoneValid), .busDoneId(busDoneId)
  );

  assign outKind = kindW;
  assign serAck  = serReq && tableEmpty;

  p_drain_r11: assert property (@(posedge clk) disable iff (!rstN)
    serAck |-> !busReqValid);

endmodule

// File: tb/pfw_handler_bench.sv
`timescale 1ns/1ps
module pfw_handler_bench;

  localparam int AW = 32;
  localparam logic [AW-1:0] LMASK = ~32'd63;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 0, reqLock = 0, busReqReady = 0, busDoneValid = 0, serReq = 0;
  logic [7:0] reqOpEsc = 0, reqOpMain = 0, reqModrm = 0;
  logic [AW-1:0] reqAddr = 0;
  logic [2:0] reqMemType = 0;
  logic [1:0] lkState = 0, busDoneId = 0;
  logic [AW-1:0] lkLineAddr, busReqAddr;
  logic busReqValid, busReqUpgrade, serAck, outValid, udFault, dbgRegOperand;
  logic [1:0] busReqId;
  logic [2:0] outKind;

  always #4 clk = ~clk;

  pfw_handler u_pfw_handler (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOpEsc(reqOpEsc),
    .reqOpMain(reqOpMain), .reqModrm(reqModrm), .reqLock(reqLock),
    .reqAddr(reqAddr), .reqMemType(reqMemType), .lkLineAddr(lkLineAddr),
    .lkState(lkState), .busReqValid(busReqValid), .busReqUpgrade(busReqUpgrade),
    .busReqAddr(busReqAddr), .busReqId(busReqId), .busReqReady(busReqReady),
    .busDoneValid(busDoneValid), .busDoneId(busDoneId), .serReq(serReq),
    .serAck(serAck), .outValid(outValid), .outKind(outKind), .udFault(udFault),
    .dbgRegOperand(dbgRegOperand)
  );

  int checks = 0, errors = 0;
  // bench model of outstanding lines
  bit mValid[4], mSent[4], mUpg[4];
  logic [AW-1:0] mAddr[4];
  bit idUsed[4];
  logic [AW-1:0] idAddr[4];
  bit mDbg = 0;
  bit eValid = 0, eFault = 0;
  logic [2:0] eKind = 0;
  // next-cycle stimulus
  bit nV, nLock, nRdy, nDone, nSer;
  logic [7:0] nEsc, nMain, nRm;
  logic [AW-1:0] nAddr;
  logic [2:0] nMt;
  logic [1:0] nSt, nDoneId;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic int mCount();
    int c = 0;
    for (int i = 0; i < 4; i++) if (mValid[i]) c++;
    return c;
  endfunction

  function automatic int mFind(input logic [AW-1:0] a);
    for (int i = 0; i < 4; i++) if (mValid[i] && mAddr[i] == a) return i;
    return -1;
  endfunction

  function automatic bit mUnsent();
    for (int i = 0; i < 4; i++) if (mValid[i] && !mSent[i]) return 1;
    return 0;
  endfunction

  task automatic setReq(input bit lock, input logic [7:0] rm, input logic [2:0] mt,
                        input logic [1:0] st, input logic [AW-1:0] a);
    nV = 1; nEsc = 8'h0F; nMain = 8'h0D; nLock = lock; nRm = rm; nMt = mt; nSt = st; nAddr = a;
  endtask

  task automatic step();
    int idx;
    logic [AW-1:0] la;
    // observe outputs settled after the last edge
    chk(outValid == eValid, "R12", "outValid", outValid, eValid);
    if (eValid) chk(outKind == eKind, "R12", "outKind", outKind, eKind);
    chk(udFault == eFault, "R2", "udFault", udFault, eFault);
    chk(dbgRegOperand == mDbg, "R3", "dbgRegOperand", dbgRegOperand, mDbg);
    chk(serAck == (serReq && mCount() == 0), "R11", "serAck", serAck, serReq && mCount() == 0);
    chk(busReqValid == mUnsent(), "R12", "busReqValid", busReqValid, mUnsent());
    if (busReqValid) begin
      idx = mFind(busReqAddr);
      chk(idx >= 0 && !mSent[idx < 0 ? 0 : idx], "R7", "busReqAddr", busReqAddr, 0);
      if (idx >= 0) chk(busReqUpgrade == mUpg[idx], "R7", "busReqUpgrade", busReqUpgrade, mUpg[idx]);
      chk(busReqAddr[5:0] == 0, "R6", "busReqAddr align", busReqAddr, busReqAddr & LMASK);
    end
    // completion choice from ids already handed to the bus
    if (nDone) begin
      nDone = 0;
      for (int k = 0; k < 4; k++) if (idUsed[(int'(nDoneId) + k) % 4] && !nDone) begin
        nDone = 1; nDoneId = 2'((int'(nDoneId) + k) % 4);
      end
    end
    // handshake at the coming edge
    if (busReqValid && nRdy) begin
      idx = mFind(busReqAddr);
      if (idx >= 0) mSent[idx] = 1;
      idUsed[busReqId] = 1; idAddr[busReqId] = busReqAddr;
    end
    // expectation for the new request
    eValid = nV && nEsc == 8'h0F && nMain == 8'h0D && nRm[5:3] == 3'd1;
    eFault = eValid && nLock;
    la = nAddr & LMASK;
    if (eValid) begin
      if (nLock) eKind = 0;
      else if (nRm[7:6] == 2'b11) begin eKind = 1; mDbg = 1; end
      else if (nMt != 3'd6) eKind = 2;
      else if (nSt >= 2) eKind = 3;
      else if (mFind(la) >= 0) eKind = 4;
      else if (mCount() == 4) eKind = 5;
      else begin
        eKind = 6;
        idx = 0;
        while (mValid[idx]) idx++;
        mValid[idx] = 1; mSent[idx] = 0; mUpg[idx] = (nSt == 2'd1); mAddr[idx] = la;
      end
    end
    if (nDone) begin
      idx = mFind(idAddr[nDoneId]);
      if (idx >= 0) mValid[idx] = 0;
      idUsed[nDoneId] = 0;
    end
    reqValid = nV; reqOpEsc = nEsc; reqOpMain = nMain; reqModrm = nRm; reqLock = nLock;
    reqAddr = nAddr; reqMemType = nMt; lkState = nSt; busReqReady = nRdy;
    busDoneValid = nDone; busDoneId = nDoneId; serReq = nSer;
    #1;
    if (nV) chk(lkLineAddr == la, "R6", "lkLineAddr", lkLineAddr, la);
    @(posedge clk); @(negedge clk);
    nV = 0; nDone = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin nV = 0; step(); end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit seedDummy;
    nV = 0; nLock = 0; nRdy = 0; nDone = 0; nSer = 1; nEsc = 0; nMain = 0; nRm = 8'h08;
    nAddr = 0; nMt = 6; nSt = 0; nDoneId = 0;
    seedDummy = 1'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    rstN = 1;
    // reset state
    chk(!outValid && !busReqValid && !udFault && !dbgRegOperand, "R12", "reset outputs", outValid, 0);
    serReq = 1; #1;
    chk(serAck == 1, "R11", "reset serAck", serAck, 1);
    @(negedge clk);
    // R1 unrecognised encodings
    setReq(0, 8'h08, 6, 0, 32'h100); nMain = 8'h18; step();
    setReq(0, 8'h10, 6, 0, 32'h100); step();
    setReq(1, 8'h08, 6, 0, 32'h100); nEsc = 8'h0E; step();
    idle(1);
    // R2 lock, even with register operand
    setReq(1, 8'h08, 6, 0, 32'h2000); step();
    setReq(1, 8'hC8, 6, 0, 32'h2000); step();
    // R3 register operand
    setReq(0, 8'hC8, 6, 0, 32'h2000); step();
    // R4 non-writeback
    setReq(0, 8'h08, 0, 0, 32'h2000); step();
    setReq(0, 8'h48, 4, 0, 32'h2000); step();
    // R5 owned hits
    setReq(0, 8'h08, 6, 2, 32'h2000); step();
    setReq(0, 8'h88, 6, 3, 32'h2000); step();
    idle(1);
    // R7 miss and shared, bus held off; R8 merge on same line
    nRdy = 0; nSer = 1;
    setReq(0, 8'h08, 6, 0, 32'h1234_5678); step();
    setReq(0, 8'h08, 6, 0, 32'h1234_567F); step();
    setReq(0, 8'h08, 6, 1, 32'h0000_9000); step();
    setReq(0, 8'h08, 6, 0, 32'h0000_A010); step();
    setReq(0, 8'h08, 6, 1, 32'h0000_B020); step();
    // R9 table full drop
    setReq(0, 8'h08, 6, 0, 32'h0000_C000); step();
    setReq(0, 8'h08, 6, 0, 32'h0000_9004); step();
    idle(2);
    // R10 hand out and complete
    nRdy = 1; idle(5);
    for (int i = 0; i < 4; i++) begin nDone = 1; nDoneId = 2'(i); step(); end
    nRdy = 0; idle(2);
    // constrained random
    for (int it = 0; it < 4000; it++) begin
      int r = $urandom_range(0, 99);
      setReq(($urandom_range(0, 99) < 5), {($urandom_range(0, 99) < 5) ? 2'b11 : 2'($urandom_range(0, 2)), 3'd1, 3'($urandom)},
             ($urandom_range(0, 99) < 85) ? 3'd6 : 3'($urandom_range(0, 5)),
             2'($urandom_range(0, 3)), 32'h4000_0000 + 32'($urandom_range(0, 7) * 64 + $urandom_range(0, 63)));
      nV = (r < 70);
      if (r < 4) nMain = 8'h0C;
      nRdy = ($urandom_range(0, 1) == 1);
      nDone = ($urandom_range(0, 99) < 35); nDoneId = 2'($urandom_range(0, 3));
      nSer = ($urandom_range(0, 1) == 1);
      step();
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule